// File: doc/BRIEF.md
# Write-Interrupted-By-Read Scheduler

This controller-side block lets a read cut short a write burst that is still transferring data, instead of waiting for the burst to finish. It tracks how many clocks have passed since the last write command and holds back any read request until the write-to-read spacing is legal. It then issues the read on the first allowed clock. A request that arrives once the spacing is already met goes out in the same clock.

When a read lands inside the write data window, the block stops driving data and strobe from the read clock onward. It raises the data-mask pattern over the residual words so that only the words already on the bus before the read are stored. It also flags the clock in which the first read data is due, which puts a gap of at least read latency minus one clocks between the release of the buses and the returning data.

The write data model is clock-granular. A write command in clock W carries its data in clocks W+1 to W+N, with two words per clock: a rising-edge word and a falling-edge word. N is the burst length divided by two. The data mask has one bit per byte lane for each of the two words. Command encoding beyond read and write, and the physical data path, are outside this block.

Top module: `wr_rd_interrupt_sched`

## Requirements
- R1: `read_issue` is never high in the clock a write command is presented (`wr_start`) or in the clock after it. A request made in either of those clocks is held and issued exactly two clocks after the write command.
- R2: A request (`rd_req`) made when neither the current nor the previous clock carries a write command raises `read_issue` in that same clock, whether or not the burst has ended.
- R3: `bl_code` 2'b00 selects burst length 2 (N=1), 2'b01 selects 4 (N=2), and 2'b10 or 2'b11 selects 8 (N=4). For a write in clock W with no interrupting read, `dq_oe` is high in clocks W+1..W+N and `dqs_oe` is high in clocks W..W+N (one preamble clock). Both are low otherwise.
- R4: If a read is issued in clock R with R-W <= N, then `dq_oe` and `dqs_oe` are low from clock R to the end of the window. Clocks before R keep their enables, and their mask is low, so that data is stored.
- R5: In such an interrupted burst, every bit of `dm` is high in clock R, masking both words of that clock on all byte lanes.
- R6: If R-W < N, then in clock R+1 only the rising-word bits `dm[BYTES-1:0]` are high. In every other clock `dm` is zero.
- R7: `rd_lat` 0 selects read latency 2 and 1 selects latency 3. `rd_data_due` is high exactly that many clocks after `read_issue`, and `dq_oe`/`dqs_oe` are low in that clock and in the clock before it.
- R8: During and right after a synchronous active-high reset, with no request or write applied, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Write command presented this clock |
| bl_code | input | 2 | Burst length select, latched with the write |
| rd_lat | input | 1 | Read latency select (0: 2 clocks, 1: 3 clocks) |
| rd_req | input | 1 | Read request strobe |
| read_issue | output | 1 | Read command goes out this clock |
| dq_oe | output | 1 | Controller drives write data this clock |
| dqs_oe | output | 1 | Controller drives the data strobe this clock |
| dm | output | 2*BYTES | Mask: low half is the rising word, high half is the falling word, one bit per byte lane |
| rd_data_due | output | 1 | First read data returns this clock |

## Verification
`read_issue`, the enables and the clock-R mask depend combinationally on the current inputs and on the write's age. They are therefore due in the same clock as the stimulus. The rising-word mask follows one clock after the read, and `rd_data_due` follows two or three clocks after it. The bench applies the inputs at each falling edge and compares every output one nanosecond later, before the next rising edge. For each clock offset from the write, it computes the expected read clock as the later of the request clock and W+2, and derives the enable window, the mask clocks and the due clock from that. The sweep covers every burst length, both latencies and every request offset from the write clock to past the burst end.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    localparam int AGE_W = 4;
    typedef logic [AGE_W-1:0] age_t;

    localparam age_t AGE_SAT = '1;
    localparam age_t MIN_WR_RD_GAP = age_t'(2);
    localparam int CL_MAX = 3;

    typedef enum logic [1:0] {
        BLC_2   = 2'b00,
        BLC_4   = 2'b01,
        BLC_8   = 2'b10,
        BLC_8X  = 2'b11
    } bl_code_e;

    typedef struct packed {
        logic dq_en;
        logic dqs_en;
        logic mask_both;
        logic mask_rise;
    } lane_ctl_t;

    function automatic age_t data_slots(input logic [1:0] code);
        case (bl_code_e'(code))
            BLC_2:   return age_t'(1);
            BLC_4:   return age_t'(2);
            default: return age_t'(4);
        endcase
    endfunction

endpackage

// File: rtl/wrs_age_track.sv
module wrs_age_track
    import wrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_start,
    input  logic [1:0] bl_code,
    output age_t       age,
    output age_t       slots
);
    age_t age_q;
    age_t slots_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q   <= AGE_SAT;
            slots_q <= age_t'(1);
        end else if (wr_start) begin
            age_q   <= age_t'(1);
            slots_q <= data_slots(bl_code);
        end else if (age_q != AGE_SAT) begin
            age_q   <= age_q + age_t'(1);
        end
    end

    assign age   = wr_start ? '0 : age_q;
    assign slots = slots_q;
endmodule

// File: rtl/wrs_read_gate.sv
module wrs_read_gate
    import wrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_start,
    input  logic rd_req,
    input  age_t age,
    output logic issue
);
    logic pend_q;
    logic want;
    logic legal;

    assign want  = rd_req | pend_q;
    assign legal = !wr_start && (age >= MIN_WR_RD_GAP);
    assign issue = want && legal;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= want && !legal;
    end
endmodule

// File: rtl/wrs_lane_ctrl.sv
module wrs_lane_ctrl
    import wrs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_start,
    input  age_t      age,
    input  age_t      slots,
    input  logic      issue,
    input  logic      rd_lat,
    output lane_ctl_t ctl,
    output logic      due
);
    logic                cut_q;
    logic                mnext_q;
    logic [CL_MAX-1:0]   due_sh_q;
    logic                in_burst;

    assign in_burst = (age >= age_t'(1)) && (age <= slots);

    always_ff @(posedge clk) begin
        if (rst) begin
            cut_q    <= 1'b0;
            mnext_q  <= 1'b0;
            due_sh_q <= '0;
        end else begin
            if (wr_start)   cut_q <= 1'b0;
            else if (issue) cut_q <= 1'b1;
            mnext_q  <= issue && in_burst && (age < slots);
            due_sh_q <= {due_sh_q[CL_MAX-2:0], issue};
        end
    end

    always_comb begin
        ctl.dq_en     = in_burst && !cut_q && !issue;
        ctl.dqs_en    = wr_start || ctl.dq_en;
        ctl.mask_both = issue && in_burst;
        ctl.mask_rise = (issue && in_burst) || mnext_q;
    end

    assign due = rd_lat ? due_sh_q[2] : due_sh_q[1];
endmodule

// File: rtl/wr_rd_interrupt_sched.sv
module wr_rd_interrupt_sched
    import wrs_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_start,
    input  logic [1:0]         bl_code,
    input  logic               rd_lat,
    input  logic               rd_req,
    output logic               read_issue,
    output logic               dq_oe,
    output logic               dqs_oe,
    output logic [2*BYTES-1:0] dm,
    output logic               rd_data_due
);
    age_t      age;
    age_t      slots;
    logic      issue;
    lane_ctl_t ctl;

    wrs_age_track u_age (
        .clk(clk), .rst(rst), .wr_start(wr_start), .bl_code(bl_code),
        .age(age), .slots(slots)
    );

    wrs_read_gate u_gate (
        .clk(clk), .rst(rst), .wr_start(wr_start), .rd_req(rd_req),
        .age(age), .issue(issue)
    );

    wrs_lane_ctrl u_lane (
        .clk(clk), .rst(rst), .wr_start(wr_start), .age(age), .slots(slots),
        .issue(issue), .rd_lat(rd_lat), .ctl(ctl), .due(rd_data_due)
    );

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            assign dm[b]         = ctl.mask_rise;
            assign dm[BYTES + b] = ctl.mask_both;
        end
    endgenerate

    assign read_issue = issue;
    assign dq_oe      = ctl.dq_en;
    assign dqs_oe     = ctl.dqs_en;
endmodule

// File: rtl/wr_rd_interrupt_sched_chk.sv
module wr_rd_interrupt_sched_chk #(
    parameter int BYTES = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_start,
    input logic               rd_req,
    input logic               read_issue,
    input logic               dq_oe,
    input logic               dqs_oe,
    input logic [2*BYTES-1:0] dm,
    input logic               rd_data_due
);
    assert_no_issue_at_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> !read_issue);

    assert_no_issue_after_write_R1: assert property (@(posedge clk) disable iff (rst)
        $past(wr_start) |-> !read_issue);

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_start && !$past(wr_start)) |-> read_issue);

    assert_preamble_R3: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> dqs_oe);

    assert_dq_needs_dqs_R3: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe);

    assert_release_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        read_issue |-> (!dq_oe && !dqs_oe));

    assert_mask_not_driven_R6: assert property (@(posedge clk) disable iff (rst)
        (|dm) |-> !dq_oe);

    assert_turnaround_gap_R7: assert property (@(posedge clk) disable iff (rst)
        rd_data_due |-> (!dq_oe && !dqs_oe && !$past(dq_oe) && !$past(dqs_oe)));
endmodule

bind wr_rd_interrupt_sched wr_rd_interrupt_sched_chk #(.BYTES(BYTES)) u_chk (
    .clk(clk), .rst(rst), .wr_start(wr_start), .rd_req(rd_req),
    .read_issue(read_issue), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .dm(dm), .rd_data_due(rd_data_due)
);

// File: tb/wr_rd_interrupt_sched_bench.sv
`timescale 1ns/1ps
module wr_rd_interrupt_sched_bench;
    localparam int BYTES = 2;
    localparam int DMW   = 2 * BYTES;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_start = 1'b0;
    logic [1:0]     bl_code = 2'b00;
    logic           rd_lat = 1'b0;
    logic           rd_req = 1'b0;
    logic           read_issue, dq_oe, dqs_oe, rd_data_due;
    logic [DMW-1:0] dm;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wr_rd_interrupt_sched #(.BYTES(BYTES)) u_wr_rd_interrupt_sched (
        .clk(clk), .rst(rst), .wr_start(wr_start), .bl_code(bl_code),
        .rd_lat(rd_lat), .rd_req(rd_req), .read_issue(read_issue),
        .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dm(dm), .rd_data_due(rd_data_due)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int all_ones;
        int rise_only;
        all_ones  = (1 << DMW) - 1;
        rise_only = (1 << BYTES) - 1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 reset issue", int'(read_issue), 0);
        chk("R8 reset dq_oe", int'(dq_oe), 0);
        chk("R8 reset dqs_oe", int'(dqs_oe), 0);
        chk("R8 reset dm", int'(dm), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R8 post-reset dqs_oe", int'(dqs_oe), 0);
        chk("R8 post-reset due", int'(rd_data_due), 0);

        for (int bl = 0; bl < 4; bl++) begin
            for (int lat = 0; lat < 2; lat++) begin
                int n;
                int cl;
                n  = (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
                cl = lat ? 3 : 2;
                for (int d = 0; d <= n + 3; d++) begin
                    int rk;
                    rk = (d < 2) ? 2 : d;
                    for (int k = 0; k <= 12; k++) begin
                        int e_dq, e_dqs, e_dm;
                        @(negedge clk);
                        wr_start = (k == 0);
                        bl_code  = 2'(bl);
                        rd_lat   = lat[0];
                        rd_req   = (k == d);
                        #1;
                        e_dq  = (k >= 1 && k <= n && k < rk) ? 1 : 0;
                        e_dqs = (k == 0 || e_dq == 1) ? 1 : 0;
                        if (k == rk && rk <= n)          e_dm = all_ones;
                        else if (k == rk + 1 && rk < n)  e_dm = rise_only;
                        else                             e_dm = 0;
                        chk((d < 2) ? "R1 held read issue" : "R2 read issue",
                            int'(read_issue), (k == rk) ? 1 : 0);
                        chk((rk <= n) ? "R4 dq_oe cut" : "R3 dq_oe window",
                            int'(dq_oe), e_dq);
                        chk((rk <= n) ? "R4 dqs_oe cut" : "R3 dqs_oe window",
                            int'(dqs_oe), e_dqs);
                        chk((k == rk) ? "R5 dm at read" : "R6 dm residual",
                            int'(dm), e_dm);
                        chk("R7 rd_data_due", int'(rd_data_due), (k == rk + cl) ? 1 : 0);
                    end
                    @(negedge clk);
                    wr_start = 1'b0;
                    rd_req   = 1'b0;
                    repeat (3) @(negedge clk);
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule